// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a processor whose instructions are all 32 bits wide, and it picks the fetch address for the next cycle. In a normal cycle the counter moves forward by one instruction, four bytes. A taken branch adds a signed word offset to the incremented address. An absolute jump writes a new low 28-bit region and keeps the top four bits of the current address. A register jump loads a full 32-bit value.

When more than one redirect is requested in the same cycle, a fixed priority picks exactly one source. A stall input freezes the counter. For the link form of the jump, the block supplies the return address (current PC plus four) in the same cycle. A flag goes high whenever a register-jump target has nonzero low bits.

Top module: `pc_next_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the PC becomes 0x00000000 on that edge. Reset takes precedence over stall and over every redirect request.
- R2: When no request is active and stall_i is low, the PC advances by 4 on each rising edge.
- R3: When stall_i is high and reset is not active, the PC keeps its value, whatever the redirect requests are.
- R4: A taken branch (br_taken_i high) loads PC + 4 + sign_extend(br_off_i) * 4. br_off_i is a 16-bit two's-complement word count. For example, a branch at 812 with offset 2 goes to 824.
- R5: An absolute jump (jmp_i high) loads {PC[31:28], jmp_idx_i, 2'b00}. For example, index 200 with upper PC bits zero goes to 800.
- R6: A register jump (jr_i high) loads jr_target_i unchanged, including its two low bits.
- R7: The priority is register jump, then absolute jump, then taken branch, then sequential increment.
- R8: link_addr_o always shows PC + 4, computed from the current PC in the same cycle.
- R9: jr_misalign_o is high combinationally exactly when jr_i is high and jr_target_i[1:0] is nonzero.
- R10: All address arithmetic wraps modulo 2^32. This applies to the increment from 0xFFFFFFFC and to backward branches below address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Holds the PC |
| br_taken_i | input | 1 | Branch taken request |
| br_off_i | input | 16 | Signed word offset of the branch |
| jmp_i | input | 1 | Absolute jump request |
| jmp_idx_i | input | 26 | Word index of the jump target |
| jr_i | input | 1 | Register jump request |
| jr_target_i | input | 32 | Register-jump target address |
| pc_o | output | 32 | Current program counter |
| link_addr_o | output | 32 | Return address, PC + 4 |
| jr_misalign_o | output | 1 | Register-jump target is not word aligned |

## Verification
The PC register is the only state in this block, so a wrong next-address choice shows up on pc_o right after the next rising edge. The return address depends on that register, so the same error also appears in link_addr_o during that cycle. A priority mistake shows up only when requests overlap, and an offset scaling or sign mistake shows up only with negative or large offsets. For these reasons the vectors combine simultaneous requests, extreme offsets, and PC values close to the wrap point and close to the top-nibble boundary.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 16;
    localparam int IDX_W   = 26;
    localparam int ALIGN_W = 2;
    localparam int INSN_BYTES = 4;
    localparam int REGION_W = ADDR_W - IDX_W - ALIGN_W;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_JR  = 2'd3
    } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
// pc_src_arb: turns the redirect requests into a single source code.
// Assumes: the requests are level signals for the current cycle. The order,
// highest first, is register jump, absolute jump, branch, then sequential.
module pc_src_arb
    import pc_next_pkg::*;
(
    input  logic    jr_req,
    input  logic    jmp_req,
    input  logic    br_req,
    output pc_src_e src
);
    // Fixed-priority select of the next-address source.
    always_comb begin
        if (jr_req)       src = SRC_JR;
        else if (jmp_req) src = SRC_JMP;
        else if (br_req)  src = SRC_BR;
        else              src = SRC_SEQ;
    end
endmodule

// File: rtl/pc_target_calc.sv
// pc_target_calc: builds every candidate next address from the current PC.
// Assumes: the offset counts instruction words and is applied to PC+4.
// The jump index counts words inside the current top region. All sums wrap.
module pc_target_calc
    import pc_next_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFF_W,
    parameter int IW = IDX_W
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] br_off,
    input  logic [IW-1:0] jmp_idx,
    output logic [AW-1:0] seq_addr,
    output logic [AW-1:0] br_addr,
    output logic [AW-1:0] jmp_addr
);
    localparam int LOW_W = IW + ALIGN_W;
    localparam int EXT_W = AW - OW - ALIGN_W;

    logic [AW-1:0] off_bytes;

    // Sign-extend the word offset and scale it to bytes.
    always_comb off_bytes = {{EXT_W{br_off[OW-1]}}, br_off, {ALIGN_W{1'b0}}};

    // Sequential, branch and jump targets (wrapping arithmetic).
    always_comb begin
        seq_addr = pc + AW'(INSN_BYTES);
        br_addr  = seq_addr + off_bytes;
        jmp_addr = {pc[AW-1:LOW_W], jmp_idx, {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/pc_next_unit.sv
// pc_next_unit: program counter register plus next-address selection.
// Assumes: synchronous active-low reset to address 0, and a stall that
// freezes the PC. Only one next-address source is used in each cycle.
module pc_next_unit
    import pc_next_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall_i,
    input  logic                br_taken_i,
    input  logic [OFF_W-1:0]    br_off_i,
    input  logic                jmp_i,
    input  logic [IDX_W-1:0]    jmp_idx_i,
    input  logic                jr_i,
    input  logic [ADDR_W-1:0]   jr_target_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   link_addr_o,
    output logic                jr_misalign_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] nxt_pc;
    logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr;
    pc_src_e           src;

    pc_src_arb u_arb (
        .jr_req  (jr_i),
        .jmp_req (jmp_i),
        .br_req  (br_taken_i),
        .src     (src)
    );

    pc_target_calc #(.AW(ADDR_W), .OW(OFF_W), .IW(IDX_W)) u_calc (
        .pc       (pc_q),
        .br_off   (br_off_i),
        .jmp_idx  (jmp_idx_i),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    // Next-address multiplexer driven by the arbiter.
    always_comb begin
        unique case (src)
            SRC_JR:  nxt_pc = jr_target_i;
            SRC_JMP: nxt_pc = jmp_addr;
            SRC_BR:  nxt_pc = br_addr;
            default: nxt_pc = seq_addr;
        endcase
    end

    // PC register: reset to zero, hold while stalled, otherwise update.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (!stall_i) pc_q <= nxt_pc;
    end

    // Output drive: current PC, return address, alignment flag.
    always_comb begin
        pc_o          = pc_q;
        link_addr_o   = seq_addr;
        jr_misalign_o = jr_i && (jr_target_i[ALIGN_W-1:0] != '0);
    end
endmodule

// File: rtl/pc_next_unit_chk.sv
// pc_next_unit_chk: temporal checks on the PC unit's ports.
module pc_next_unit_chk
    import pc_next_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stall_i,
    input logic              br_taken_i,
    input logic [OFF_W-1:0]  br_off_i,
    input logic              jmp_i,
    input logic [IDX_W-1:0]  jmp_idx_i,
    input logic              jr_i,
    input logic [ADDR_W-1:0] jr_target_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] link_addr_o,
    input logic              jr_misalign_o
);
    logic seen_rst;
    // Marks that at least one reset edge has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0);

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        stall_i |=> $stable(pc_o));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!stall_i && !jr_i && !jmp_i && !br_taken_i) |=> pc_o == $past(pc_o) + 32'd4);

    assert_jr_load_R6: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!stall_i && jr_i) |=> pc_o == $past(jr_target_i));

    assert_jmp_region_R5: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!stall_i && !jr_i && jmp_i) |=> pc_o[31:28] == $past(pc_o[31:28]));

    // R8: link address tracks the register.
    always_comb if (rst_n && seen_rst === 1'b1)
        assert_link_R8: assert (link_addr_o == pc_o + 32'd4);

    // R9: misalignment flag follows the target low bits.
    always_comb if (rst_n && seen_rst === 1'b1)
        assert_misalign_R9: assert (jr_misalign_o == (jr_i && jr_target_i[1:0] != 2'b00));
endmodule

bind pc_next_unit pc_next_unit_chk u_chk (.*);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic        br_taken_i = 1'b0;
    logic [15:0] br_off_i = '0;
    logic        jmp_i = 1'b0;
    logic [25:0] jmp_idx_i = '0;
    logic        jr_i = 1'b0;
    logic [31:0] jr_target_i = '0;
    logic [31:0] pc_o, link_addr_o;
    logic        jr_misalign_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pc_next_unit u_pc_next_unit (.*);

    // Vector: {start_pc, stall, br, off, jmp, idx, jr, tgt, expected_next}
    typedef struct packed {
        logic [31:0] start;
        logic        st;
        logic        br;
        logic [15:0] off;
        logic        jp;
        logic [25:0] idx;
        logic        jr;
        logic [31:0] tgt;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'd812,       0,1,16'd2,     0,26'd0,  0,32'd0,        32'd824},       // R4 example
        '{32'd0,         0,0,16'd0,     1,26'd200,0,32'd0,        32'd800},       // R5 example
        '{32'd100,       0,1,16'hFFFF,  0,26'd0,  0,32'd0,        32'd100},       // R4 negative
        '{32'd0,         0,1,16'h8000,  0,26'd0,  0,32'd0,        32'hFFFE0004},  // R10 wrap under zero
        '{32'd0,         0,1,16'h7FFF,  0,26'd0,  0,32'd0,        32'h00020000},  // R4 max positive
        '{32'hFFFFFFFC,  0,0,16'd0,     0,26'd0,  0,32'd0,        32'd0},         // R10 seq wrap
        '{32'hA0000010,  0,0,16'd0,     1,26'h3FFFFFF,0,32'd0,    32'hAFFFFFFC},  // R5 keep top
        '{32'd64,        0,0,16'd0,     0,26'd0,  1,32'h12345677, 32'h12345677},  // R6 low bits kept
        '{32'd64,        0,1,16'd5,     1,26'd10, 1,32'h00000F00, 32'h00000F00},  // R7 jr wins
        '{32'h70000000,  0,1,16'd5,     1,26'd10, 0,32'd0,        32'h70000028},  // R7 jmp over br
        '{32'd40,        1,1,16'd5,     1,26'd10, 1,32'h00000F00, 32'd40},        // R3 stall
        '{32'd40,        0,0,16'd0,     0,26'd0,  0,32'd0,        32'd44}         // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        stall_i = 0; br_taken_i = 0; jmp_i = 0; jr_i = 0;
    endtask

    // Move the PC to a chosen value with a register jump.
    task automatic set_pc(input logic [31:0] v);
        idle(); jr_i = 1; jr_target_i = v;
        @(posedge clk); #1;
        idle();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0;
        repeat (2) @(posedge clk); #1;
        check("R1 reset", pc_o, 32'd0);
        rst_n = 1;
        @(posedge clk); #1;
        check("R2 step", pc_o, 32'd4);
        check("R8 link", link_addr_o, 32'd8);

        for (int i = 0; i < NV; i++) begin
            set_pc(VECS[i].start);
            stall_i = VECS[i].st; br_taken_i = VECS[i].br; br_off_i = VECS[i].off;
            jmp_i = VECS[i].jp; jmp_idx_i = VECS[i].idx;
            jr_i = VECS[i].jr; jr_target_i = VECS[i].tgt;
            #1;
            check("R8 link same cycle", link_addr_o, VECS[i].start + 32'd4);
            @(posedge clk); #1;
            check($sformatf("R4-7 vector %0d", i), pc_o, VECS[i].exp);
            idle();
        end

        // R9 misalignment flag.
        idle(); jr_i = 1; jr_target_i = 32'h102; stall_i = 1; #1;
        check("R9 flag high", {31'd0, jr_misalign_o}, 32'd1);
        jr_target_i = 32'h100; #1;
        check("R9 flag low aligned", {31'd0, jr_misalign_o}, 32'd0);
        jr_i = 0; jr_target_i = 32'h103; #1;
        check("R9 flag low no jr", {31'd0, jr_misalign_o}, 32'd0);
        idle();

        // R1 reset overrides stall and requests.
        set_pc(32'h500);
        rst_n = 0; stall_i = 1; jr_i = 1; jr_target_i = 32'h900;
        @(posedge clk); #1;
        check("R1 reset beats stall/jr", pc_o, 32'd0);
        rst_n = 1; idle();

        // R3 multi-cycle stall.
        set_pc(32'h200);
        stall_i = 1;
        repeat (3) @(posedge clk); #1;
        check("R3 stall hold", pc_o, 32'h200);
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule